// File: doc/BRIEF.md
# External Pin and Pin-Change Interrupt Detector

This block turns raw pin activity into interrupt requests. One dedicated interrupt pin is judged by a selectable sense mode. The four modes are low level, any change, falling edge and rising edge. Twelve general pins are watched for toggles in either direction and form two groups. The lower group holds pins 0 to 7 and the upper group holds pins 8 to 11. Each group has its own per-pin mask and its own sticky request flag.

Every pin passes through a two-flop synchronizer. An edge is found by comparing the synchronized value with the sample taken one cycle earlier, and that earlier sample keeps tracking the pin whatever the mask or mode is. The inputs are plain pin values, so a pin that the chip drives as an output still raises events. Software can use this to raise an interrupt by writing the pin.

Each request output is its flag gated by that source's enable. In low-level mode the request instead follows the synchronized pin directly and is never latched.

Top module: `irq_pin_detect`

## Requirements
- R1: A toggle in either direction on any of `pc_pins[7:0]` whose bit in `pc_mask0` is 1 sets the group 0 flag, which appears on `pc_req[0]`.
- R2: A toggle on any of `pc_pins[11:8]` whose bit in `pc_mask1` is 1 (bit i covers pin 8+i) sets only the group 1 flag (`pc_req[1]`) and leaves group 0 untouched.
- R3: A toggle on a pin whose mask bit is 0 sets no flag.
- R4: With `ext_mode` = 2'b10 (falling edge), a high-to-low transition of `ext_pin` sets the dedicated flag, and a low-to-high transition does not.
- R5: With `ext_mode` = 2'b11 (rising edge), a low-to-high transition of `ext_pin` sets the dedicated flag, and a high-to-low transition does not.
- R6: With `ext_mode` = 2'b00 (low level), `ext_req` is high exactly while the synchronized `ext_pin` is low and `ext_en` is 1. Nothing is latched, so the request drops once the pin returns high.
- R7: With `ext_mode` = 2'b01 (any change), every transition of `ext_pin` sets the dedicated flag.
- R8: Edge-mode and pin-change flags hold until a one-cycle clear strobe (`ext_clr`, `pc_clr[g]`). If a new event arrives in the same cycle as the clear, the flag stays set.
- R9: A request output is its flag ANDed with its enable. A flag is still recorded while the enable is 0, and it appears as soon as the enable goes to 1.
- R10: Changing a mask bit or `ext_mode` while the pins are steady produces no event.
- R11: After a pin change, an edge-mode or pin-change request rises after the third rising clock edge, and a low-level request rises after the second.
- R12: During reset and in the first cycles after it, all requests are low, and pins that already sit at a level different from the idle value raise no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_pin | input | 1 | Dedicated interrupt pin |
| pc_pins | input | 12 | Pin-change pins; [7:0] are group 0 and [11:8] are group 1 |
| ext_mode | input | 2 | Sense mode: 00 low, 01 any change, 10 falling, 11 rising |
| pc_mask0 | input | 8 | Per-pin contribution mask for group 0 |
| pc_mask1 | input | 4 | Per-pin contribution mask for group 1 |
| ext_en | input | 1 | Enable for the dedicated request |
| pc_en | input | 2 | Enable per pin-change group |
| ext_clr | input | 1 | One-cycle clear of the dedicated flag |
| pc_clr | input | 2 | One-cycle clear per group flag |
| ext_req | output | 1 | Dedicated interrupt request |
| pc_req | output | 2 | Pin-change request per group |

## Verification
The bench lines up a clear strobe with the exact cycle in which a new toggle is detected. A design that gives the clear priority would lose that event, and the flag would read 0 instead of 1. Pins are held away from their idle level through reset to catch a design that sees the synchronizer fill as a toggle. Masks and the sense mode are changed while the pins are steady; a design that compares against stale or mode-gated samples would then raise a false request. The bench samples one cycle before and at the expected latency, so an extra or missing pipeline stage shows up. The low-level test releases the pin and checks that the request drops, which exposes a design that latches it.

// File: rtl/irq_det_pkg.sv
package irq_det_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  // Edge qualification for the dedicated pin; low-level mode never yields an event.
  function automatic logic sense_hit(sense_e mode, logic prv, logic cur);
    logic res;
    case (mode)
      SENSE_ANY:  res = prv ^ cur;
      SENSE_FALL: res = prv & ~cur;
      SENSE_RISE: res = ~prv & cur;
      default:    res = 1'b0;
    endcase
    return res;
  endfunction

  // Sticky flag update: a fresh event outranks the clear strobe.
  function automatic logic flag_next(logic flag, logic clr, logic evt);
    return (flag & ~clr) | evt;
  endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int   W    = 13,
  parameter logic IDLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prv_o,
  output logic         primed_o
);
  localparam int FILL = 3;
  localparam int CW   = $clog2(FILL + 1);

  logic [W-1:0]  stg1, stg2, prev;
  logic [CW-1:0] fill_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg1     <= {W{IDLE}};
      stg2     <= {W{IDLE}};
      prev     <= {W{IDLE}};
      fill_cnt <= '0;
    end else begin
      stg1 <= pin_i;
      stg2 <= stg1;
      prev <= stg2;
      if (fill_cnt != CW'(FILL)) fill_cnt <= fill_cnt + 1'b1;
    end
  end

  assign cur_o    = stg2;
  assign prv_o    = prev;
  assign primed_o = (fill_cnt == CW'(FILL));

  // R12: until the pipeline has filled, nothing is reported as valid
  p_unprimed_after_reset_r12: assert property (@(posedge clk)
    $rose(rst_n) |-> !primed_o);

endmodule

// File: rtl/irq_pc_group.sv
module irq_pc_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] tog_i,
  input  logic         en_i,
  input  logic         clr_i,
  output logic         hit_o,
  output logic         req_o
);
  import irq_det_pkg::*;

  logic flag;

  assign hit_o = |(mask_i & tog_i);

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_next(flag, clr_i, hit_o);
  end

  assign req_o = flag & en_i;

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr_i |=> flag);

  p_flag_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag && clr_i && !hit_o |=> !flag);

  p_flag_has_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit_o));

  p_req_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !req_o);

endmodule

// File: rtl/irq_ext_sense.sv
module irq_ext_sense (
  input  logic                  clk,
  input  logic                  rst_n,
  input  irq_det_pkg::sense_e   mode_i,
  input  logic                  cur_i,
  input  logic                  prv_i,
  input  logic                  primed_i,
  input  logic                  en_i,
  input  logic                  clr_i,
  output logic                  evt_o,
  output logic                  req_o
);
  import irq_det_pkg::*;

  logic flag;
  logic low_seen;

  assign evt_o    = primed_i & sense_hit(mode_i, prv_i, cur_i);
  assign low_seen = primed_i & ~cur_i;

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_next(flag, clr_i, evt_o);
  end

  always_comb begin
    if (mode_i == SENSE_LOW) req_o = en_i & low_seen;
    else                     req_o = en_i & flag;
  end

  p_low_unlatched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SENSE_LOW) && cur_i |-> !req_o);

  p_low_no_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SENSE_LOW) && !flag |=> !flag);

  p_ext_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr_i |=> flag);

endmodule

// File: rtl/irq_pin_detect.sv
module irq_pin_detect #(
  parameter int G0_W = 8,
  parameter int G1_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ext_pin,
  input  logic [G0_W+G1_W-1:0] pc_pins,
  input  logic [1:0]           ext_mode,
  input  logic [G0_W-1:0]      pc_mask0,
  input  logic [G1_W-1:0]      pc_mask1,
  input  logic                 ext_en,
  input  logic [1:0]           pc_en,
  input  logic                 ext_clr,
  input  logic [1:0]           pc_clr,
  output logic                 ext_req,
  output logic [1:0]           pc_req
);
  import irq_det_pkg::*;

  localparam int PC_W = G0_W + G1_W;
  localparam int NPIN = PC_W + 1;

  logic [NPIN-1:0] cur, prv;
  logic            primed;
  logic [PC_W-1:0] pc_tog;
  logic            ext_evt;
  logic [1:0]      pc_hit;

  irq_pin_sync #(.W(NPIN), .IDLE(1'b1)) sync_i (
    .clk(clk), .rst_n(rst_n), .pin_i({pc_pins, ext_pin}),
    .cur_o(cur), .prv_o(prv), .primed_o(primed)
  );

  assign pc_tog = primed ? (cur[NPIN-1:1] ^ prv[NPIN-1:1]) : '0;

  irq_ext_sense ext_i (
    .clk(clk), .rst_n(rst_n), .mode_i(sense_e'(ext_mode)),
    .cur_i(cur[0]), .prv_i(prv[0]), .primed_i(primed),
    .en_i(ext_en), .clr_i(ext_clr), .evt_o(ext_evt), .req_o(ext_req)
  );

  irq_pc_group #(.W(G0_W)) grp0_i (
    .clk(clk), .rst_n(rst_n), .mask_i(pc_mask0), .tog_i(pc_tog[G0_W-1:0]),
    .en_i(pc_en[0]), .clr_i(pc_clr[0]), .hit_o(pc_hit[0]), .req_o(pc_req[0])
  );

  irq_pc_group #(.W(G1_W)) grp1_i (
    .clk(clk), .rst_n(rst_n), .mask_i(pc_mask1), .tog_i(pc_tog[PC_W-1:G0_W]),
    .en_i(pc_en[1]), .clr_i(pc_clr[1]), .hit_o(pc_hit[1]), .req_o(pc_req[1])
  );

  // R12: no event of any kind before the synchronizer has filled
  p_quiet_unprimed_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !ext_evt && (pc_hit == 2'b00));

  // R3: a fully masked group never reports a hit
  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_mask0 == '0) |-> !pc_hit[0]);

endmodule

// File: tb/irq_pin_detect_tb_top.sv
module irq_pin_detect_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_pin;
  logic [11:0] pc_pins;
  logic [1:0]  ext_mode;
  logic [7:0]  pc_mask0;
  logic [3:0]  pc_mask1;
  logic        ext_en;
  logic [1:0]  pc_en;
  logic        ext_clr;
  logic [1:0]  pc_clr;
  logic        ext_req;
  logic [1:0]  pc_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  irq_pin_detect dut_i (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .pc_pins(pc_pins),
    .ext_mode(ext_mode), .pc_mask0(pc_mask0), .pc_mask1(pc_mask1),
    .ext_en(ext_en), .pc_en(pc_en), .ext_clr(ext_clr), .pc_clr(pc_clr),
    .ext_req(ext_req), .pc_req(pc_req)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    ext_clr = 1'b1; pc_clr = 2'b11;
    tick(1);
    ext_clr = 1'b0; pc_clr = 2'b00;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ext_pin = 1'b1; pc_pins = 12'h000;
    ext_mode = 2'b00; pc_mask0 = 8'hFF; pc_mask1 = 4'hF;
    ext_en = 1'b1; pc_en = 2'b11; ext_clr = 1'b0; pc_clr = 2'b00;
    tick(3);
    chk("R12 ext in reset", ext_req, 1'b0);
    chk("R12 pc in reset", pc_req[0] | pc_req[1], 1'b0);
    rst_n = 1'b1;
    tick(6);
    chk("R12 grp0 quiet after fill", pc_req[0], 1'b0);
    chk("R12 grp1 quiet after fill", pc_req[1], 1'b0);
    chk("R12 ext quiet after fill", ext_req, 1'b0);
    pc_pins = 12'hFFF;
    tick(4);
    chk("R1 all pins rise", pc_req[0], 1'b1);
    clear_all();
    chk("R8 clear strobe", pc_req[0] | pc_req[1], 1'b0);
    pc_mask0 = 8'h00; pc_mask1 = 4'h0;
  endtask

  task automatic t_group0();
    pc_mask0 = 8'h04;
    pc_pins[2] = 1'b0;
    tick(2);
    chk("R11 grp0 not yet", pc_req[0], 1'b0);
    tick(1);
    chk("R11 grp0 third edge", pc_req[0], 1'b1);
    chk("R1 grp0 falling toggle", pc_req[0], 1'b1);
    chk("R2 grp1 untouched", pc_req[1], 1'b0);
    tick(5);
    chk("R8 grp0 holds", pc_req[0], 1'b1);
    clear_all();
    pc_pins[2] = 1'b1;
    tick(3);
    chk("R1 grp0 rising toggle", pc_req[0], 1'b1);
    clear_all();
    pc_mask0 = 8'h00;
  endtask

  task automatic t_group1();
    pc_mask1 = 4'b1000;
    pc_pins[11] = 1'b0;
    tick(3);
    chk("R2 grp1 pin 11", pc_req[1], 1'b1);
    chk("R2 grp0 untouched", pc_req[0], 1'b0);
    clear_all();
    pc_pins[9] = 1'b0;
    tick(4);
    chk("R3 grp1 masked pin 9", pc_req[1], 1'b0);
    pc_mask1 = 4'h0;
  endtask

  task automatic t_mask();
    pc_mask0 = 8'h01;
    pc_pins[5] = 1'b0;
    tick(4);
    chk("R3 grp0 masked pin 5", pc_req[0], 1'b0);
    pc_mask0 = 8'hFF; pc_mask1 = 4'hF;
    tick(4);
    chk("R10 grp0 mask change", pc_req[0], 1'b0);
    chk("R10 grp1 mask change", pc_req[1], 1'b0);
    pc_mask0 = 8'h00; pc_mask1 = 4'h0;
  endtask

  task automatic t_ext_fall();
    ext_mode = 2'b10; ext_en = 1'b1;
    tick(2);
    ext_pin = 1'b0;
    tick(2);
    chk("R11 fall not yet", ext_req, 1'b0);
    tick(1);
    chk("R4 falling edge", ext_req, 1'b1);
    clear_all();
    ext_pin = 1'b1;
    tick(4);
    chk("R4 rise ignored", ext_req, 1'b0);
  endtask

  task automatic t_ext_rise();
    ext_mode = 2'b11;
    tick(3);
    chk("R10 mode change quiet", ext_req, 1'b0);
    ext_pin = 1'b0;
    tick(4);
    chk("R5 fall ignored", ext_req, 1'b0);
    ext_pin = 1'b1;
    tick(3);
    chk("R5 rising edge", ext_req, 1'b1);
    clear_all();
  endtask

  task automatic t_ext_any();
    ext_mode = 2'b01;
    tick(2);
    ext_pin = 1'b0;
    tick(3);
    chk("R7 any change fall", ext_req, 1'b1);
    clear_all();
    ext_pin = 1'b1;
    tick(3);
    chk("R7 any change rise", ext_req, 1'b1);
    clear_all();
  endtask

  task automatic t_low();
    ext_mode = 2'b00;
    tick(2);
    chk("R6 high pin no req", ext_req, 1'b0);
    ext_pin = 1'b0;
    tick(1);
    chk("R11 low not yet", ext_req, 1'b0);
    tick(1);
    chk("R6 low level req", ext_req, 1'b1);
    ext_en = 1'b0;
    #1;
    chk("R6 low needs enable", ext_req, 1'b0);
    ext_en = 1'b1;
    ext_pin = 1'b1;
    tick(2);
    chk("R6 not latched", ext_req, 1'b0);
  endtask

  task automatic t_enable();
    pc_mask0 = 8'h02; pc_en[0] = 1'b0;
    pc_pins[1] = 1'b0;
    tick(4);
    chk("R9 disabled quiet", pc_req[0], 1'b0);
    pc_en[0] = 1'b1;
    #1;
    chk("R9 pending shows", pc_req[0], 1'b1);
    clear_all();
    pc_mask0 = 8'h00;
  endtask

  task automatic t_collide();
    pc_mask0 = 8'h01;
    pc_pins[0] = 1'b0;
    tick(3);
    chk("R1 collide setup", pc_req[0], 1'b1);
    pc_pins[0] = 1'b1;
    tick(1);
    tick(1);
    pc_clr[0] = 1'b1;
    tick(1);
    pc_clr[0] = 1'b0;
    chk("R8 event beats clear", pc_req[0], 1'b1);
    pc_clr[0] = 1'b1;
    tick(1);
    pc_clr[0] = 1'b0;
    chk("R8 plain clear", pc_req[0], 1'b0);
    pc_mask0 = 8'h00;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_group0();
    t_group1();
    t_mask();
    t_ext_fall();
    t_ext_rise();
    t_ext_any();
    t_low();
    t_enable();
    t_collide();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule